// File: doc/BRIEF.md
# Region Permission Checker

This block decides, for every memory access, whether a small register-held table of protection regions allows it. An access request gives a start address, a byte count, an access kind (read, write, execute or portal entry), the issuing thread and the protection domain ("turf") it runs in. Each table slot holds an inclusive low and high bound, an owning thread, an owning turf and four rights bits. The slots are searched from index 0 upwards. The first slot that on its own allows the whole access decides the result. Rights are never pooled across slots. One cycle later the block reports whether the access is allowed, which slot allowed it, and the kind and address of the access, so that a fault handler can use them.

A second port adds regions. An ordinary grant is issued on behalf of the running thread, whose thread and turf identity come from dedicated inputs and not from the request. It succeeds only if one existing slot already gives that thread, in that turf, every right being granted over the whole granted range. Each thread has its own grant quota counter. A privileged register-write port loads it, and every successful ordinary grant lowers it by one. A privileged install path bypasses the rights and quota checks so that the first regions can be set up. New regions go into the lowest free slot. A full table rejects the grant and never overwrites an existing slot.

Top module: `rgn_guard`

## Requirements
- R1: When several slots allow an access, the result reports the lowest-indexed of them.
- R2: An access is allowed only if a single slot satisfies low <= addr and addr+len-1 <= high. Two overlapping or touching slots that each cover only part of the bytes give a fault.
- R3: A slot allows an access only if it is valid, its thread equals the request thread, its turf equals the request turf, and it holds the needed right.
- R4: The access kind codes are 0 read, 1 write, 2 execute and 3 portal. They need rights bits 0 (R), 1 (W), 2 (X) and 3 (P) respectively. A data access never uses X or P, and an instruction-side access never uses R or W.
- R5: A zero length, or an access whose last byte passes the top of the address space, always faults. Every result, including a fault, returns the request's kind and start address.
- R6: res_valid is high in exactly the cycle after each cycle with chk_valid high. On a fault res_ok is 0 and res_idx is 0.
- R7: An ordinary grant needs a single slot with thread cur_tid, turf cur_turf, a range containing [gnt_lo, gnt_hi] and a superset of gnt_rights. If no such slot exists, or if gnt_hi < gnt_lo, the grant returns code 2.
- R8: An ordinary grant made while the quota of cur_tid is zero returns code 1 and adds no slot. Each successful ordinary grant lowers that quota by one.
- R9: qld_we writes qld_val into the quota of thread qld_tid. The quotas of different threads are independent.
- R10: A grant made while every slot is valid returns code 3 and leaves all slots unchanged. When more than one failure applies, code 1 takes priority over code 2, and code 2 over code 3.
- R11: After reset the table is empty, every quota is zero and res_valid and gnt_done are low.
- R12: A grant with gnt_priv high ignores quota and rights. It fails only on a full table. A successful grant returns code 0 and the slot it filled on gnt_slot, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Access request strobe |
| chk_addr | input | AW | Access start address |
| chk_len | input | LW | Access length in bytes |
| chk_kind | input | 2 | Access kind code |
| chk_tid | input | TIDW | Issuing thread |
| chk_turf | input | TURFW | Issuing turf |
| res_valid | output | 1 | Result strobe |
| res_ok | output | 1 | 1 = allowed, 0 = fault |
| res_idx | output | IW | Deciding slot |
| res_kind | output | 2 | Kind of the checked access |
| res_addr | output | AW | Start address of the checked access |
| cur_tid | input | TIDW | Running thread identity for grants |
| cur_turf | input | TURFW | Running turf identity for grants |
| gnt_valid | input | 1 | Grant request strobe |
| gnt_priv | input | 1 | Privileged install, checks bypassed |
| gnt_lo | input | AW | Low bound of new region |
| gnt_hi | input | AW | High bound of new region |
| gnt_tid | input | TIDW | Thread owning new region |
| gnt_turf | input | TURFW | Turf owning new region |
| gnt_rights | input | 4 | Rights of new region {P,X,W,R} |
| gnt_done | output | 1 | Grant result strobe |
| gnt_code | output | 2 | 0 ok, 1 quota, 2 rights, 3 full |
| gnt_slot | output | IW | Slot filled by a successful grant |
| qld_we | input | 1 | Privileged quota write |
| qld_tid | input | TIDW | Thread whose quota is written |
| qld_val | input | QW | Quota value |

## Verification
The bench builds the block with a 16-bit address space, 6-bit lengths, 2-bit thread and turf identities, 3-bit quotas and only five slots. The small table lets a few grants fill it, so the full-table rejection and its no-overwrite guarantee can be reached in a short run. The 16-bit address lets an access near 0xFFFF wrap past the top. With small quotas, exhaustion and reload take only one or two grants, and the order in which failures are reported can be observed on a single request.

// File: rtl/rgn_guard_pkg.sv
`timescale 1ns/1ps
package rgn_guard_pkg;
  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2,
    ACC_PT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    GC_OK     = 2'd0,
    GC_QUOTA  = 2'd1,
    GC_RIGHTS = 2'd2,
    GC_FULL   = 2'd3
  } gnt_code_e;

  localparam int NRIGHTS = 4;
endpackage

// File: rtl/rgn_match.sv
`timescale 1ns/1ps
module rgn_match #(
  parameter int AW    = 32,
  parameter int TIDW  = 4,
  parameter int TURFW = 4
) (
  input  logic             e_vld,
  input  logic [AW-1:0]    e_lo,
  input  logic [AW-1:0]    e_hi,
  input  logic [TIDW-1:0]  e_tid,
  input  logic [TURFW-1:0] e_turf,
  input  logic [3:0]       e_rts,
  input  logic [AW-1:0]    q_lo,
  input  logic [AW-1:0]    q_hi,
  input  logic [TIDW-1:0]  q_tid,
  input  logic [TURFW-1:0] q_turf,
  input  logic [3:0]       q_need,
  output logic             hit
);
  logic covers, who_ok, rts_ok;

  always_comb begin
    covers = (e_lo <= q_lo) && (q_hi <= e_hi);
    who_ok = (e_tid == q_tid) && (e_turf == q_turf);
    rts_ok = ((e_rts & q_need) == q_need);
    hit    = e_vld && covers && who_ok && rts_ok;
  end
endmodule

// File: rtl/rgn_first.sv
`timescale 1ns/1ps
module rgn_first #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
    any |-> (hits[idx] && ((hits & ((N'(1) << idx) - N'(1))) == '0))); // R1
endmodule

// File: rtl/rgn_table.sv
`timescale 1ns/1ps
module rgn_table #(
  parameter int NENT  = 16,
  parameter int AW    = 32,
  parameter int TIDW  = 4,
  parameter int TURFW = 4,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_lo,
  input  logic [AW-1:0]    wr_hi,
  input  logic [TIDW-1:0]  wr_tid,
  input  logic [TURFW-1:0] wr_turf,
  input  logic [3:0]       wr_rts,
  output logic             vld  [NENT],
  output logic [AW-1:0]    lo   [NENT],
  output logic [AW-1:0]    hi   [NENT],
  output logic [TIDW-1:0]  tid  [NENT],
  output logic [TURFW-1:0] turf [NENT],
  output logic [3:0]       rts  [NENT],
  output logic             full,
  output logic [IW-1:0]    free_idx
);
  always_comb begin
    full     = 1'b1;
    free_idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        full     = 1'b0;
        free_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) begin
        vld[i]  <= 1'b0;
        lo[i]   <= '0;
        hi[i]   <= '0;
        tid[i]  <= '0;
        turf[i] <= '0;
        rts[i]  <= '0;
      end
    end else if (wr_en) begin
      vld[free_idx]  <= 1'b1;
      lo[free_idx]   <= wr_lo;
      hi[free_idx]   <= wr_hi;
      tid[free_idx]  <= wr_tid;
      turf[free_idx] <= wr_turf;
      rts[free_idx]  <= wr_rts;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R10
  AST_FILL_MARKS_SLOT: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld[$past(free_idx)]); // R12
endmodule

// File: rtl/rgn_quota.sv
`timescale 1ns/1ps
module rgn_quota #(
  parameter int TIDW = 4,
  parameter int QW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic [TIDW-1:0] ld_tid,
  input  logic [QW-1:0]   ld_val,
  input  logic            dec_en,
  input  logic [TIDW-1:0] dec_tid,
  input  logic [TIDW-1:0] rd_tid,
  output logic [QW-1:0]   rd_val
);
  localparam int NTHR = 1 << TIDW;

  logic [QW-1:0] cnt [NTHR];

  assign rd_val = cnt[rd_tid];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTHR; i++) cnt[i] <= '0;
    end else begin
      if (dec_en && !(ld_we && ld_tid == dec_tid))
        cnt[dec_tid] <= cnt[dec_tid] - QW'(1);
      if (ld_we)
        cnt[ld_tid] <= ld_val;
    end
  end

  AST_QUOTA_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec_en |-> (cnt[dec_tid] != '0)); // R8
endmodule

// File: rtl/rgn_guard.sv
`timescale 1ns/1ps
module rgn_guard
  import rgn_guard_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 8,
  parameter int TIDW  = 4,
  parameter int TURFW = 4,
  parameter int NENT  = 16,
  parameter int QW    = 8,
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_valid,
  input  logic [AW-1:0]    chk_addr,
  input  logic [LW-1:0]    chk_len,
  input  logic [1:0]       chk_kind,
  input  logic [TIDW-1:0]  chk_tid,
  input  logic [TURFW-1:0] chk_turf,
  output logic             res_valid,
  output logic             res_ok,
  output logic [IW-1:0]    res_idx,
  output logic [1:0]       res_kind,
  output logic [AW-1:0]    res_addr,
  input  logic [TIDW-1:0]  cur_tid,
  input  logic [TURFW-1:0] cur_turf,
  input  logic             gnt_valid,
  input  logic             gnt_priv,
  input  logic [AW-1:0]    gnt_lo,
  input  logic [AW-1:0]    gnt_hi,
  input  logic [TIDW-1:0]  gnt_tid,
  input  logic [TURFW-1:0] gnt_turf,
  input  logic [3:0]       gnt_rights,
  output logic             gnt_done,
  output logic [1:0]       gnt_code,
  output logic [IW-1:0]    gnt_slot,
  input  logic             qld_we,
  input  logic [TIDW-1:0]  qld_tid,
  input  logic [QW-1:0]    qld_val
);
  // table state
  logic             t_vld  [NENT];
  logic [AW-1:0]    t_lo   [NENT];
  logic [AW-1:0]    t_hi   [NENT];
  logic [TIDW-1:0]  t_tid  [NENT];
  logic [TURFW-1:0] t_turf [NENT];
  logic [3:0]       t_rts  [NENT];
  logic             t_full;
  logic [IW-1:0]    t_free;

  // access path
  logic [AW:0]     c_end;
  logic            c_bad;
  logic [3:0]      c_need;
  logic [NENT-1:0] c_raw, c_hits;
  logic            c_any;
  logic [IW-1:0]   c_idx;

  // grant path
  logic [NENT-1:0] g_hits;
  logic            g_rts_ok;
  logic [QW-1:0]   q_cur;
  gnt_code_e       g_code;
  logic            g_wr, g_dec;

  always_comb begin
    c_end  = {1'b0, chk_addr} + (AW + 1)'(chk_len) - (AW + 1)'(1);
    c_bad  = (chk_len == '0) || c_end[AW];
    c_need = 4'b0001 << chk_kind;
    c_hits = c_bad ? '0 : c_raw;
  end

  for (genvar gi = 0; gi < NENT; gi++) begin : g_ent
    rgn_match #(.AW(AW), .TIDW(TIDW), .TURFW(TURFW)) u_acc (
      .e_vld(t_vld[gi]), .e_lo(t_lo[gi]), .e_hi(t_hi[gi]),
      .e_tid(t_tid[gi]), .e_turf(t_turf[gi]), .e_rts(t_rts[gi]),
      .q_lo(chk_addr), .q_hi(c_end[AW-1:0]), .q_tid(chk_tid),
      .q_turf(chk_turf), .q_need(c_need), .hit(c_raw[gi])
    );
    rgn_match #(.AW(AW), .TIDW(TIDW), .TURFW(TURFW)) u_gnt (
      .e_vld(t_vld[gi]), .e_lo(t_lo[gi]), .e_hi(t_hi[gi]),
      .e_tid(t_tid[gi]), .e_turf(t_turf[gi]), .e_rts(t_rts[gi]),
      .q_lo(gnt_lo), .q_hi(gnt_hi), .q_tid(cur_tid),
      .q_turf(cur_turf), .q_need(gnt_rights), .hit(g_hits[gi])
    );
  end

  rgn_first #(.N(NENT), .IW(IW)) u_first (
    .clk(clk), .rst(rst), .hits(c_hits), .any(c_any), .idx(c_idx)
  );

  rgn_quota #(.TIDW(TIDW), .QW(QW)) u_quota (
    .clk(clk), .rst(rst),
    .ld_we(qld_we), .ld_tid(qld_tid), .ld_val(qld_val),
    .dec_en(g_dec), .dec_tid(cur_tid),
    .rd_tid(cur_tid), .rd_val(q_cur)
  );

  always_comb begin
    g_rts_ok = (|g_hits) && (gnt_lo <= gnt_hi);
    if (gnt_priv)          g_code = t_full ? GC_FULL : GC_OK;
    else if (q_cur == '0)  g_code = GC_QUOTA;
    else if (!g_rts_ok)    g_code = GC_RIGHTS;
    else if (t_full)       g_code = GC_FULL;
    else                   g_code = GC_OK;
    g_wr  = gnt_valid && (g_code == GC_OK);
    g_dec = g_wr && !gnt_priv;
  end

  rgn_table #(.NENT(NENT), .AW(AW), .TIDW(TIDW), .TURFW(TURFW), .IW(IW)) u_table (
    .clk(clk), .rst(rst), .wr_en(g_wr),
    .wr_lo(gnt_lo), .wr_hi(gnt_hi), .wr_tid(gnt_tid),
    .wr_turf(gnt_turf), .wr_rts(gnt_rights),
    .vld(t_vld), .lo(t_lo), .hi(t_hi), .tid(t_tid),
    .turf(t_turf), .rts(t_rts), .full(t_full), .free_idx(t_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_idx   <= '0;
      res_kind  <= '0;
      res_addr  <= '0;
      gnt_done  <= 1'b0;
      gnt_code  <= '0;
      gnt_slot  <= '0;
    end else begin
      res_valid <= chk_valid;
      if (chk_valid) begin
        res_ok   <= c_any;
        res_idx  <= c_any ? c_idx : '0;
        res_kind <= chk_kind;
        res_addr <= chk_addr;
      end
      gnt_done <= gnt_valid;
      if (gnt_valid) begin
        gnt_code <= g_code;
        gnt_slot <= t_free;
      end
    end
  end

  AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(chk_valid)); // R6
  AST_WRAP_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(c_bad)) |-> !res_ok); // R5
  AST_GRANT_NEEDS_QUOTA: assert property (@(posedge clk) disable iff (rst)
    (gnt_done && $past(!gnt_priv && q_cur == '0)) |-> (gnt_code != GC_OK)); // R8
endmodule

// File: tb/sim_rgn_guard.sv
`timescale 1ns/1ps
module sim_rgn_guard;
  localparam int AW = 16, LW = 6, TIDW = 2, TURFW = 2, NENT = 5, QW = 3;
  localparam int IW = 3;

  logic clk = 0, rst = 1;
  logic chk_valid = 0;
  logic [AW-1:0] chk_addr = 0;
  logic [LW-1:0] chk_len = 0;
  logic [1:0] chk_kind = 0;
  logic [TIDW-1:0] chk_tid = 0;
  logic [TURFW-1:0] chk_turf = 0;
  logic res_valid, res_ok;
  logic [IW-1:0] res_idx;
  logic [1:0] res_kind;
  logic [AW-1:0] res_addr;
  logic [TIDW-1:0] cur_tid = 0;
  logic [TURFW-1:0] cur_turf = 0;
  logic gnt_valid = 0, gnt_priv = 0;
  logic [AW-1:0] gnt_lo = 0, gnt_hi = 0;
  logic [TIDW-1:0] gnt_tid = 0;
  logic [TURFW-1:0] gnt_turf = 0;
  logic [3:0] gnt_rights = 0;
  logic gnt_done;
  logic [1:0] gnt_code;
  logic [IW-1:0] gnt_slot;
  logic qld_we = 0;
  logic [TIDW-1:0] qld_tid = 0;
  logic [QW-1:0] qld_val = 0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rgn_guard #(.AW(AW), .LW(LW), .TIDW(TIDW), .TURFW(TURFW), .NENT(NENT), .QW(QW)) u0 (.*);

  // {addr16, len6, kind2, tid2, turf2, ok1, idx3}
  localparam logic [31:0] VEC [14] = '{
    {16'h1000, 6'd4, 2'd0, 2'd1, 2'd1, 1'b1, 3'd0},  // R1 first of two
    {16'h1000, 6'd4, 2'd1, 2'd1, 2'd1, 1'b1, 3'd1},  // R1 slot0 lacks W
    {16'h10FC, 6'd4, 2'd0, 2'd1, 2'd1, 1'b1, 3'd0},  // R2 ends on high bound
    {16'h10FD, 6'd4, 2'd0, 2'd1, 2'd1, 1'b1, 3'd1},  // R2 spills past slot0
    {16'h1FFE, 6'd4, 2'd0, 2'd1, 2'd1, 1'b0, 3'd0},  // R2 no joining
    {16'h1000, 6'd4, 2'd0, 2'd2, 2'd1, 1'b0, 3'd0},  // R3 thread
    {16'h1000, 6'd4, 2'd0, 2'd1, 2'd2, 1'b0, 3'd0},  // R3 turf
    {16'h2000, 6'd2, 2'd2, 2'd1, 2'd1, 1'b1, 3'd2},  // R4 execute
    {16'h2000, 6'd2, 2'd1, 2'd1, 2'd1, 1'b0, 3'd0},  // R3 right missing
    {16'h1000, 6'd2, 2'd2, 2'd1, 2'd1, 1'b0, 3'd0},  // R4 RW gives no X
    {16'h2000, 6'd2, 2'd3, 2'd1, 2'd1, 1'b0, 3'd0},  // R4 X gives no P
    {16'hFFFE, 6'd4, 2'd0, 2'd1, 2'd1, 1'b0, 3'd0},  // R5 wrap
    {16'h1000, 6'd0, 2'd0, 2'd1, 2'd1, 1'b0, 3'd0},  // R5 zero length
    {16'h0FFF, 6'd2, 2'd0, 2'd1, 2'd1, 1'b0, 3'd0}   // R2 below low bound
  };

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [LW-1:0] l,
                        input logic [1:0] k, input logic [TIDW-1:0] t,
                        input logic [TURFW-1:0] f, input bit ok,
                        input int idx, input string req);
    @(negedge clk);
    chk_addr = a; chk_len = l; chk_kind = k; chk_tid = t; chk_turf = f;
    chk_valid = 1;
    @(negedge clk);
    chk_valid = 0;
    cmp({req, " ok"}, int'(res_valid & res_ok), int'(ok));
    cmp({req, " idx/kind/addr"}, int'({res_idx, res_kind, res_addr}),
        int'({IW'(ok ? idx : 0), k, a}));
  endtask

  task automatic grant(input bit pv, input logic [TIDW-1:0] ct,
                       input logic [TURFW-1:0] cf, input logic [AW-1:0] lo,
                       input logic [AW-1:0] hi, input logic [TIDW-1:0] t,
                       input logic [TURFW-1:0] f, input logic [3:0] r,
                       input int code, input int slot, input string req);
    @(negedge clk);
    gnt_priv = pv; cur_tid = ct; cur_turf = cf; gnt_lo = lo; gnt_hi = hi;
    gnt_tid = t; gnt_turf = f; gnt_rights = r; gnt_valid = 1;
    @(negedge clk);
    gnt_valid = 0;
    cmp({req, " code"}, int'({gnt_done, gnt_code}), int'({1'b1, 2'(code)}));
    if (code == 0) cmp({req, " slot"}, int'(gnt_slot), slot);
  endtask

  task automatic qload(input logic [TIDW-1:0] t, input logic [QW-1:0] v);
    @(negedge clk);
    qld_tid = t; qld_val = v; qld_we = 1;
    @(negedge clk);
    qld_we = 0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cmp("R11 res_valid low", int'(res_valid), 0);
    cmp("R11 gnt_done low", int'(gnt_done), 0);
    access(16'h1000, 6'd1, 2'd0, 2'd0, 2'd0, 0, 0, "R11 empty table");
    @(negedge clk);
    cmp("R6 res_valid drops", int'(res_valid), 0);

    // R12 privileged installs with zero quota everywhere
    grant(1, 0, 0, 16'h1000, 16'h10FF, 1, 1, 4'b0001, 0, 0, "R12 install0");
    grant(1, 0, 0, 16'h1000, 16'h1FFF, 1, 1, 4'b0011, 0, 1, "R12 install1");
    grant(1, 0, 0, 16'h2000, 16'h20FF, 1, 1, 4'b0101, 0, 2, "R12 install2");

    for (int i = 0; i < 14; i++)
      access(VEC[i][31:16], VEC[i][15:10], VEC[i][9:8], VEC[i][7:6],
             VEC[i][5:4], VEC[i][3], int'(VEC[i][2:0]),
             $sformatf("vector %0d", i));

    // R8 zero quota blocks ordinary grant
    grant(0, 1, 1, 16'h1100, 16'h11FF, 2, 2, 4'b0001, 1, 0, "R8 no quota");
    qload(1, 3'd1);  // R9
    grant(0, 1, 1, 16'h1100, 16'h11FF, 2, 2, 4'b0001, 0, 3, "R7 covered grant");
    access(16'h1100, 6'd4, 2'd0, 2'd2, 2'd2, 1, 3, "R7 granted read");
    access(16'h1100, 6'd4, 2'd1, 2'd2, 2'd2, 0, 0, "R7 only granted rights");
    grant(0, 1, 1, 16'h2000, 16'h203F, 3, 3, 4'b0100, 1, 0, "R8 quota used up");
    qload(1, 3'd1);
    grant(0, 1, 1, 16'h2000, 16'h203F, 3, 3, 4'b0100, 0, 4, "R9 reload");
    access(16'h2000, 6'd1, 2'd2, 2'd3, 2'd3, 1, 4, "R8 failed grant added nothing");
    qload(1, 3'd3);
    grant(0, 1, 1, 16'h2000, 16'h2001, 0, 0, 4'b0010, 2, 0, "R7 rights before full");
    grant(0, 1, 1, 16'h2010, 16'h2000, 0, 0, 4'b0001, 2, 0, "R7 inverted range");
    grant(0, 1, 1, 16'h1000, 16'h100F, 0, 0, 4'b0001, 3, 0, "R10 full");
    grant(1, 0, 0, 16'h3000, 16'h30FF, 0, 0, 4'b1111, 3, 0, "R10 full privileged");
    access(16'h1000, 6'd4, 2'd0, 2'd1, 2'd1, 1, 0, "R10 slot0 intact");
    access(16'h1100, 6'd4, 2'd0, 2'd2, 2'd2, 1, 3, "R10 slot3 intact");
    grant(0, 2, 2, 16'h1100, 16'h1101, 0, 0, 4'b0001, 1, 0, "R9 per-thread quota");
    report();
  end
endmodule